// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block keeps a position count from a two-phase incremental encoder, or counts free-running clock cycles when no encoder is in use. Two phase inputs, A and B, reach the block already synchronised to its clock. A small register port lets software start and stop counting, pick one of four counting modes, load the count directly, set the wrap ceiling and read back a direction flag that shows which way the last step went.

The ceiling has an optional staging path. With staging off, a ceiling write acts in the very next cycle. With staging on, the new value waits in a pending register until software writes the event register. Software changes mode by stopping the counter, writing the new mode, issuing an event, and then starting it again. Mode writes that arrive while the counter runs are dropped, so a running count never jumps from one decoding rule to another.

Register map (word address on `wr_addr`/`rd_addr`): 0 = control, 1 = count, 2 = ceiling (reads return the active value), 3 = event (write only, reads as zero).

Top module: `qenc_counter`

## Requirements
- R1: After reset the count is 0, the direction flag is 0, the control register reads 0 and the active ceiling is all ones.
- R2: In mode 0 (control bits [2:1] = 0) with run (control bit 0) set, the count rises by one on every clock and the A and B inputs have no effect.
- R3: With run clear, the count holds in every mode, whatever A and B do.
- R4: In mode 1 the count steps on every rising and falling edge of A: up when the new A differs from B, down when they are equal. Edges of B alone cause no step.
- R5: In mode 2 the count steps on every edge of B: up when the new B equals A, down when they differ. Edges of A alone cause no step.
- R6: In mode 3 every single-phase edge of A or B is one step, with the direction rules of R4 and R5, so one full quadrature cycle is four counts.
- R7: In modes 1 to 3, a cycle in which A and B both change produces no step.
- R8: An up step from a count at or above the active ceiling gives 0, and a down step from 0 gives the active ceiling.
- R9: The direction flag (control bit 4, read only, also on `dir_o`) becomes 1 after a down step and 0 after an up step, and holds between steps.
- R10: With staging (control bit 3) clear, a write to address 2 sets the active ceiling in the next cycle.
- R11: With staging set, a write to address 2 leaves the active ceiling unchanged until a write to address 3 with bit 0 set copies the pending value across.
- R12: A write to address 1 loads the count, and it wins over a step in the same cycle.
- R13: A control write while run is already set updates run and staging but leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_in | input | 1 | Encoder phase A, synchronous |
| b_in | input | 1 | Encoder phase B, synchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | CNT_W | Read data, combinational from `rd_addr` |
| count_o | output | CNT_W | Current count |
| dir_o | output | 1 | Direction of the last step, 1 = down |

## Verification
The checks assume that A and B are already synchronous to the clock, and that the inputs never sit at 1 during reset. Because the edge history resets to zero, a phase held high through reset would show up as a spurious edge in the first cycle. The stimulus therefore holds both phases low through reset. After that it changes at most one phase per cycle, except in the one deliberate double change that tests R7. The checks also assume one register write per cycle and count values no larger than the active ceiling. The bench only writes counts below the ceiling, and it changes mode only while stopped, following the stop, mode, event, start order.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
   typedef enum logic [1:0] {
      QM_INTERNAL = 2'd0,
      QM_EDGE_A   = 2'd1,
      QM_EDGE_B   = 2'd2,
      QM_BOTH     = 2'd3
   } qenc_mode_e;

   localparam logic [1:0] REG_CTRL  = 2'd0;
   localparam logic [1:0] REG_COUNT = 2'd1;
   localparam logic [1:0] REG_CEIL  = 2'd2;
   localparam logic [1:0] REG_EVENT = 2'd3;

   localparam int CTRL_RUN   = 0;
   localparam int CTRL_MODE  = 1;
   localparam int CTRL_STAGE = 3;
   localparam int CTRL_DIR   = 4;
   localparam int CTRL_BITS  = 5;
endpackage

// File: rtl/qenc_step_gen.sv
module qenc_step_gen
   import qenc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       a_in,
   input  logic       b_in,
   input  logic       run,
   input  qenc_mode_e mode,
   output logic       step,
   output logic       down
);
   logic a_q, b_q;
   logic a_edge, b_edge, a_up, b_up;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_q <= 1'b0;
         b_q <= 1'b0;
      end else begin
         a_q <= a_in;
         b_q <= b_in;
      end
   end

   assign a_edge = a_in ^ a_q;
   assign b_edge = b_in ^ b_q;
   // A leading B counts up
   assign a_up   = a_in ^ b_in;
   assign b_up   = ~(a_in ^ b_in);

   always_comb begin
      step = 1'b0;
      down = 1'b0;
      if (run) begin
         unique case (mode)
            QM_INTERNAL: step = 1'b1;
            QM_EDGE_A: begin
               step = a_edge & ~b_edge;
               down = ~a_up;
            end
            QM_EDGE_B: begin
               step = b_edge & ~a_edge;
               down = ~b_up;
            end
            QM_BOTH: begin
               step = a_edge ^ b_edge;
               down = a_edge ? ~a_up : ~b_up;
            end
            default: step = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/qenc_wrap_counter.sv
module qenc_wrap_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             down,
   input  logic [CNT_W-1:0] ceil,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count,
   output logic             dir
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
         dir   <= 1'b0;
      end else begin
         if (load)
            count <= load_val;
         else if (step && down)
            count <= (count == '0) ? ceil : count - ONE;
         else if (step)
            count <= (count >= ceil) ? '0 : count + ONE;
         if (step)
            dir <= down;
      end
   end
endmodule

// File: rtl/qenc_ceiling.sv
module qenc_ceiling #(
   parameter int CNT_W   = 16,
   parameter bit PRELOAD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CNT_W-1:0] wr_val,
   input  logic             stage_en,
   input  logic             update,
   output logic [CNT_W-1:0] active
);
   generate
      if (PRELOAD) begin : g_staged
         logic [CNT_W-1:0] pending;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pending <= '1;
               active  <= '1;
            end else begin
               if (wr)
                  pending <= wr_val;
               if (wr && !stage_en)
                  active <= wr_val;
               else if (update)
                  active <= pending;
            end
         end
      end else begin : g_direct
         logic unused_inputs;
         assign unused_inputs = stage_en ^ update;
         always_ff @(posedge clk) begin
            if (!rst_n)
               active <= '1;
            else if (wr)
               active <= wr_val;
         end
      end
   endgenerate
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
   import qenc_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter bit PRELOAD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             a_in,
   input  logic             b_in,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [1:0]       rd_addr,
   output logic [CNT_W-1:0] rd_data,
   output logic [CNT_W-1:0] count_o,
   output logic             dir_o
);
   generate
      if (CNT_W < CTRL_BITS || CNT_W > 32) begin : g_bad_width
         $error("qenc_counter: CNT_W must lie in 5..32");
      end
   endgenerate

   logic             run_q, stage_q;
   qenc_mode_e       mode_q;
   logic             step, down;
   logic [CNT_W-1:0] ceil_act;
   logic             wr_ctrl, wr_cnt, wr_ceil, upd_evt;

   assign wr_ctrl = wr_en && (wr_addr == REG_CTRL);
   assign wr_cnt  = wr_en && (wr_addr == REG_COUNT);
   assign wr_ceil = wr_en && (wr_addr == REG_CEIL);
   assign upd_evt = wr_en && (wr_addr == REG_EVENT) && wr_data[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         stage_q <= 1'b0;
         mode_q  <= QM_INTERNAL;
      end else if (wr_ctrl) begin
         run_q   <= wr_data[CTRL_RUN];
         stage_q <= wr_data[CTRL_STAGE];
         if (!run_q)
            mode_q <= qenc_mode_e'(wr_data[CTRL_MODE +: 2]);
      end
   end

   qenc_step_gen u_step (
      .clk   (clk),
      .rst_n (rst_n),
      .a_in  (a_in),
      .b_in  (b_in),
      .run   (run_q),
      .mode  (mode_q),
      .step  (step),
      .down  (down)
   );

   qenc_ceiling #(.CNT_W(CNT_W), .PRELOAD(PRELOAD)) u_ceil (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (wr_ceil),
      .wr_val   (wr_data),
      .stage_en (stage_q),
      .update   (upd_evt),
      .active   (ceil_act)
   );

   qenc_wrap_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .down     (down),
      .ceil     (ceil_act),
      .load     (wr_cnt),
      .load_val (wr_data),
      .count    (count_o),
      .dir      (dir_o)
   );

   always_comb begin
      rd_data = '0;
      unique case (rd_addr)
         REG_CTRL: begin
            rd_data[CTRL_RUN]        = run_q;
            rd_data[CTRL_MODE +: 2]  = mode_q;
            rd_data[CTRL_STAGE]      = stage_q;
            rd_data[CTRL_DIR]        = dir_o;
         end
         REG_COUNT: rd_data = count_o;
         REG_CEIL:  rd_data = ceil_act;
         default:   rd_data = '0;
      endcase
   end
endmodule

// File: rtl/qenc_counter_chk.sv
module qenc_counter_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             a_in,
   input logic             b_in,
   input logic             wr_en,
   input logic [1:0]       wr_addr,
   input logic [CNT_W-1:0] count_o,
   input logic             dir_o,
   input logic             run,
   input logic [1:0]       mode,
   input logic             stage,
   input logic [CNT_W-1:0] ceil_act
);
   logic cnt_wr;
   assign cnt_wr = wr_en && (wr_addr == 2'd1);

   // R2
   internal_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && mode == 2'd0 && !cnt_wr) |=>
      count_o == (($past(count_o) >= $past(ceil_act)) ? '0 : CNT_W'($past(count_o) + 1)));

   // R3
   stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cnt_wr) |=> $stable(count_o));

   // R7
   double_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && mode != 2'd0 && !cnt_wr && a_in != $past(a_in) && b_in != $past(b_in))
      |=> $stable(count_o));

   // R9
   up_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && mode == 2'd0) |=> !dir_o);

   // R11
   staged_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd2 && stage) |=> ceil_act == $past(ceil_act));

   // R13
   mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd0 && run) |=> mode == $past(mode));
endmodule

bind qenc_counter qenc_counter_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .a_in     (a_in),
   .b_in     (b_in),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .count_o  (count_o),
   .dir_o    (dir_o),
   .run      (run_q),
   .mode     (mode_q),
   .stage    (stage_q),
   .ceil_act (ceil_act)
);

// File: tb/tb_qenc_counter.sv
`timescale 1ns/1ps
module tb_qenc_counter;
   localparam int W    = 16;
   localparam int MASK = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         a_in = 1'b0, b_in = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_addr = '0;
   logic [W-1:0] wr_data = '0;
   logic [1:0]   rd_addr = '0;
   logic [W-1:0] rd_data, count_o;
   logic         dir_o;

   int nchk = 0, nfail = 0;
   bit cmp_on = 0, done = 0;
   int qidx = 0;

   // behavioural reference state
   int m_cnt, m_dir, m_run, m_mode, m_stage, m_ceil, m_pend, m_pa, m_pb;
   int stp, dn, ea, eb;

   always #2.5 clk = ~clk;

   qenc_counter #(.CNT_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .count_o(count_o), .dir_o(dir_o)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_dir = 0; m_run = 0; m_mode = 0; m_stage = 0;
         m_ceil = MASK; m_pend = MASK; m_pa = 0; m_pb = 0;
      end else begin
         stp = 0; dn = 0;
         ea = (a_in != m_pa); eb = (b_in != m_pb);
         if (m_run) begin
            if (m_mode == 0) stp = 1;
            else if (ea && eb) stp = 0;
            else if (ea && (m_mode == 1 || m_mode == 3)) begin
               stp = 1; dn = (a_in == b_in);
            end else if (eb && (m_mode == 2 || m_mode == 3)) begin
               stp = 1; dn = (a_in != b_in);
            end
         end
         if (stp) begin
            if (dn) m_cnt = (m_cnt == 0) ? m_ceil : m_cnt - 1;
            else    m_cnt = (m_cnt >= m_ceil) ? 0 : m_cnt + 1;
            m_dir = dn;
         end
         if (wr_en) begin
            case (wr_addr)
               2'd0: begin
                  if (!m_run) m_mode = int'(wr_data[2:1]);
                  m_run = wr_data[0]; m_stage = wr_data[3];
               end
               2'd1: m_cnt = int'(wr_data);
               2'd2: begin
                  m_pend = int'(wr_data);
                  if (!m_stage) m_ceil = int'(wr_data);
               end
               default: if (wr_data[0]) m_ceil = m_pend;
            endcase
         end
         m_pa = a_in; m_pb = b_in;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // per-clock comparison with the reference (R2 R4 R5 R6 R8 R9 R12)
   always @(negedge clk) begin
      if (cmp_on && !done) begin
         chk("R8 model count", int'(count_o), m_cnt);
         chk("R9 model dir", int'(dir_o), m_dir);
      end
   end

   task automatic wr(input int addr, input int data);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = addr[1:0]; wr_data = data[W-1:0];
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_phase();
      a_in = (qidx == 1 || qidx == 2);
      b_in = (qidx == 2 || qidx == 3);
   endtask

   task automatic qstep(input bit up, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         qidx = up ? (qidx + 1) % 4 : (qidx + 3) % 4;
         set_phase();
      end
   endtask

   task automatic rdchk(input string tag, input int addr, input int exp);
      @(negedge clk);
      rd_addr = addr[1:0];
      #1;
      chk(tag, int'(rd_data), exp);
   endtask

   task automatic cntchk(input string tag, input int exp);
      @(negedge clk);
      chk(tag, int'(count_o), exp);
   endtask

   task automatic set_mode(input int md);
      wr(0, md << 1);
      wr(3, 1);
      wr(0, (md << 1) | 1);
   endtask

   int saved;

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cmp_on = 1;
      // R1 reset state
      cntchk("R1 count", 0);
      chk("R1 dir", int'(dir_o), 0);
      rdchk("R1 ctrl", 0, 0);
      rdchk("R1 ceiling", 2, MASK);
      // R10 immediate ceiling
      wr(2, 10);
      rdchk("R10 ceiling", 2, 10);
      // R2 internal counting, phases moving meanwhile
      wr(0, 1);
      qstep(1, 6);
      repeat (8) @(negedge clk);
      chk("R2 count", int'(count_o), m_cnt);
      // R13 mode write while running
      wr(0, 7);
      rdchk("R13 ctrl", 0, 1);
      // R3 stopped
      wr(0, 0);
      @(negedge clk);
      saved = int'(count_o);
      qstep(1, 4);
      cntchk("R3 hold", saved);
      // R4 mode 1
      set_mode(1);
      wr(1, 5);
      qstep(1, 8);
      cntchk("R4 up", 9);
      qstep(0, 8);
      cntchk("R4 down", 5);
      chk("R9 dir down", int'(dir_o), 1);
      // R5 mode 2
      wr(0, 0);
      set_mode(2);
      wr(1, 2);
      qstep(1, 8);
      cntchk("R5 up", 6);
      chk("R9 dir up", int'(dir_o), 0);
      // R6 / R8 mode 3
      wr(0, 0);
      set_mode(3);
      wr(1, 0);
      qstep(0, 1);
      cntchk("R8 down wrap", 10);
      qstep(1, 1);
      cntchk("R8 up wrap", 0);
      qstep(1, 4);
      cntchk("R6 four per cycle", 4);
      // R7 double change
      @(negedge clk);
      a_in = ~a_in; b_in = ~b_in;
      qidx = a_in ? (b_in ? 2 : 1) : (b_in ? 3 : 0);
      cntchk("R7 no step", 4);
      // R11 staged ceiling
      wr(0, 15);
      wr(2, 20);
      rdchk("R11 held", 2, 10);
      wr(3, 1);
      rdchk("R11 loaded", 2, 20);
      // R12 count write beats a step
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'd3;
      qidx = (qidx + 1) % 4;
      set_phase();
      @(negedge clk);
      wr_en = 1'b0;
      chk("R12 load wins", int'(count_o), 3);
      repeat (3) @(negedge clk);
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1;
         nchk++; nfail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end
endmodule